// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a 16-bit microcontroller address into exactly one memory select. The possible targets are four main flash sectors, four boot flash sectors, one SRAM select and one I/O-space select. Each target owns one or more address-range terms. Each term is an enable bit plus a base/mask pair, loaded one at a time through a simple write port. An address hits a term when the address and the base agree on every bit that the mask sets.

Overlaps between levels are legal and are settled by a fixed order. SRAM and I/O come first, boot sectors second and main sectors last. After loading, software pulses a start strobe. A sequential scanner then walks every pair of terms and every term's window size, and raises an error if two selects of the same level overlap or a window exceeds its physical sector. Decoding stays off until the scan has finished clean. While it is on, the block drives a one-hot select vector and the in-window offset. When no term hits, it raises an unmapped flag.

Top module: `cs_prio_decoder`

## Requirements
- R1: After reset, cfg_done, cfg_error, unmapped and every bit of mem_sel are low.
- R2: A term write (cfg_we) clears cfg_done on the next clock edge. While cfg_done is low, mem_sel is all zeros and unmapped is low for any address.
- R3: After a cfg_start pulse, cfg_done rises within NT*NT+4 cycles, where NT is the term count (12 by default). cfg_error is only ever high together with cfg_done.
- R4: A term is indexed by cfg_idx. Indices 0–3 are main sectors 0–3, 4–7 are boot sectors 0–3, 8–10 are SRAM terms and 11 is the I/O term. An enabled term matches when (addr & mask) == (base & mask). A disabled term never matches.
- R5: A match on the SRAM or I/O level beats any boot match, and a boot match beats any main match. With main 0 over 8000h–BFFFh, boot 0 over 8000h–9FFFh and SRAM over 8000h–87FFh: 8000h–87FFh selects SRAM, 8800h–9FFFh selects boot 0, and A000h–BFFFh selects main 0.
- R6: The SRAM select is the OR of its three terms, so it may cover several separate windows.
- R7: The scan sets cfg_error when two enabled terms of different selects on the same level overlap. The cases are main vs main, boot vs boot, and SRAM vs I/O. Overlap between SRAM terms, and overlap across levels, is not an error. Two windows overlap when ((base_a ^ base_b) & mask_a & mask_b) == 0.
- R8: The scan sets cfg_error when an enabled term's window (2 to the count of zero mask bits) is larger than its physical size. The physical sizes are 2^14 for main, 2^13 for boot, 2^11 for SRAM and 2^8 for I/O.
- R9: While cfg_error is high, mem_sel is zero and unmapped is low.
- R10: With decoding enabled and no term matching, unmapped is high and mem_sel is zero.
- R11: offset equals addr & ~mask of the winning term: the first hit in the order SRAM terms 8–10, I/O, boot sectors, main sectors. offset is zero when no select is driven.
- R12: mem_sel has at most one bit set. Bits 0–3 are main sectors, bits 4–7 are boot sectors, bit 8 is SRAM and bit 9 is I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one range term |
| cfg_idx | input | 4 | Index of the term being written |
| cfg_en | input | 1 | Enable bit of the written term |
| cfg_base | input | 16 | Base address of the written term |
| cfg_mask | input | 16 | Compare mask of the written term |
| cfg_start | input | 1 | Start the legality scan |
| addr | input | 16 | Address to decode |
| cfg_done | output | 1 | Scan finished; decoding allowed if no error |
| cfg_error | output | 1 | Illegal mapping found |
| mem_sel | output | 10 | One-hot memory select |
| offset | output | 16 | Address bits inside the selected window |
| unmapped | output | 1 | Decoding enabled and no term matched |

## Verification
A corrupted term register shows up as a wrong select or offset on the same cycle as the first address that falls into the damaged window. If the damage makes two same-level windows collide, it also appears as cfg_error at the end of the next scan. A scanner whose pair or index counters go wrong either misses a seeded overlap or size fault, so cfg_error stays low when it should rise, or fails to finish, so cfg_done does not arrive inside the NT*NT+4 bound. A broken priority chain gives a lower-level select inside the worked-case windows straight away.

// File: rtl/cs_prio_pkg.sv
`timescale 1ns/1ps
package cs_prio_pkg;

    typedef enum logic [1:0] {
        LVL_MAIN = 2'd0,
        LVL_BOOT = 2'd1,
        LVL_TOP  = 2'd2
    } level_e;

    // level of a term index: main sectors, then boot sectors, then SRAM/I-O
    function automatic level_e lvl_of(int idx, int nmain, int nboot);
        if (idx < nmain)              return LVL_MAIN;
        else if (idx < nmain + nboot) return LVL_BOOT;
        else                          return LVL_TOP;
    endfunction

    // select bit driven by a term index
    function automatic int sid_of(int idx, int nmain, int nboot, int nsram);
        if (idx < nmain + nboot)              return idx;
        else if (idx < nmain + nboot + nsram) return nmain + nboot;
        else                                  return nmain + nboot + 1;
    endfunction

    // term visited at priority position p (top level first, main last)
    function automatic int order_of(int p, int nmain, int nboot, int ntop);
        if (p < ntop)              return nmain + nboot + p;
        else if (p < ntop + nboot) return nmain + (p - ntop);
        else                       return p - ntop - nboot;
    endfunction

endpackage

// File: rtl/cs_term_store.sv
`timescale 1ns/1ps
module cs_term_store #(
    parameter int ADDR_W = 16,
    parameter int NT     = 12,
    parameter int TIW    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [TIW-1:0]               cfg_idx,
    input  logic                         cfg_en,
    input  logic [ADDR_W-1:0]            cfg_base,
    input  logic [ADDR_W-1:0]            cfg_mask,
    output logic [NT-1:0]                term_en,
    output logic [NT-1:0][ADDR_W-1:0]    term_base,
    output logic [NT-1:0][ADDR_W-1:0]    term_mask
);

    typedef struct packed {
        logic [NT-1:0]             en;
        logic [NT-1:0][ADDR_W-1:0] base;
        logic [NT-1:0][ADDR_W-1:0] mask;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < NT; t++) begin
            if (cfg_we && (cfg_idx == TIW'(t))) begin
                st_d.en[t]   = cfg_en;
                st_d.base[t] = cfg_base;
                st_d.mask[t] = cfg_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign term_en   = st_q.en;
    assign term_base = st_q.base;
    assign term_mask = st_q.mask;

endmodule

// File: rtl/cs_cfg_scan.sv
`timescale 1ns/1ps
module cs_cfg_scan
    import cs_prio_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NMAIN     = 4,
    parameter int NBOOT     = 4,
    parameter int NSRAM     = 3,
    parameter int NT        = 12,
    parameter int MAIN_BITS = 14,
    parameter int BOOT_BITS = 13,
    parameter int SRAM_BITS = 11,
    parameter int IO_BITS   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_start,
    input  logic [NT-1:0]             term_en,
    input  logic [NT-1:0][ADDR_W-1:0] term_base,
    input  logic [NT-1:0][ADDR_W-1:0] term_mask,
    output logic                      cfg_done,
    output logic                      cfg_error
);

    localparam int IW        = (NT > 1) ? $clog2(NT) : 1;
    localparam int SCAN_MAX  = NT * NT + 4;
    localparam int BCW       = $clog2(SCAN_MAX + 2) + 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          err;
        logic [IW-1:0] i;
        logic [IW-1:0] j;
    } scan_t;

    scan_t sc_d, sc_q;

    logic              en_i, en_j;
    logic [ADDR_W-1:0] base_i, base_j, mask_i, mask_j;
    logic              pair_bad, size_bad;
    int                lim_i;

    // operand fetch for the pair under test
    always_comb begin
        en_i = 1'b0; en_j = 1'b0;
        base_i = '0; base_j = '0; mask_i = '0; mask_j = '0;
        for (int t = 0; t < NT; t++) begin
            if (sc_q.i == IW'(t)) begin
                en_i = term_en[t]; base_i = term_base[t]; mask_i = term_mask[t];
            end
            if (sc_q.j == IW'(t)) begin
                en_j = term_en[t]; base_j = term_base[t]; mask_j = term_mask[t];
            end
        end
    end

    always_comb begin
        if (int'(sc_q.i) < NMAIN)                  lim_i = MAIN_BITS;
        else if (int'(sc_q.i) < NMAIN + NBOOT)     lim_i = BOOT_BITS;
        else if (int'(sc_q.i) < NT - 1)            lim_i = SRAM_BITS;
        else                                       lim_i = IO_BITS;

        pair_bad = (sc_q.j > sc_q.i) && en_i && en_j
                 && (lvl_of(int'(sc_q.i), NMAIN, NBOOT) == lvl_of(int'(sc_q.j), NMAIN, NBOOT))
                 && (sid_of(int'(sc_q.i), NMAIN, NBOOT, NSRAM) != sid_of(int'(sc_q.j), NMAIN, NBOOT, NSRAM))
                 && (((base_i ^ base_j) & mask_i & mask_j) == '0);

        size_bad = (sc_q.j == '0) && en_i && ($countones(~mask_i) > lim_i);
    end

    always_comb begin
        sc_d = sc_q;
        if (cfg_we) begin
            sc_d.busy = 1'b0;
            sc_d.done = 1'b0;
            sc_d.err  = 1'b0;
        end else if (cfg_start) begin
            sc_d.busy = 1'b1;
            sc_d.done = 1'b0;
            sc_d.err  = 1'b0;
            sc_d.i    = '0;
            sc_d.j    = '0;
        end else if (sc_q.busy) begin
            if (pair_bad || size_bad) sc_d.err = 1'b1;
            if (sc_q.j == IW'(NT - 1)) begin
                sc_d.j = '0;
                if (sc_q.i == IW'(NT - 1)) begin
                    sc_d.busy = 1'b0;
                    sc_d.done = 1'b1;
                end else begin
                    sc_d.i = sc_q.i + 1'b1;
                end
            end else begin
                sc_d.j = sc_q.j + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign cfg_done  = sc_q.done;
    assign cfg_error = sc_q.done & sc_q.err;

    // ---------------- assertions ----------------
    logic [BCW-1:0] busy_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 busy_cnt_q <= '0;
        else if (cfg_start || cfg_we) busy_cnt_q <= '0;
        else if (sc_q.busy)         busy_cnt_q <= busy_cnt_q + 1'b1;
    end

    p_scan_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt_q <= BCW'(SCAN_MAX));

    p_err_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> cfg_done);

    p_write_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !cfg_done);

    p_done_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && !cfg_we && !cfg_start) |=> (cfg_done && $stable(cfg_error)));

endmodule

// File: rtl/cs_sel_resolve.sv
`timescale 1ns/1ps
module cs_sel_resolve
    import cs_prio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NMAIN  = 4,
    parameter int NBOOT  = 4,
    parameter int NSRAM  = 3,
    parameter int NT     = 12,
    parameter int NSEL   = 10
) (
    input  logic                      dec_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NT-1:0]             term_en,
    input  logic [NT-1:0][ADDR_W-1:0] term_base,
    input  logic [NT-1:0][ADDR_W-1:0] term_mask,
    output logic [NSEL-1:0]           sel,
    output logic [ADDR_W-1:0]         offset,
    output logic                      unmapped
);

    localparam int NTOP = NSRAM + 1;

    logic [NT-1:0]     hit;
    logic              found;
    int                win;
    int                wsid;
    logic [ADDR_W-1:0] wmask;

    // per-term window compare
    for (genvar g = 0; g < NT; g++) begin : g_hit
        assign hit[g] = term_en[g] &&
                        ((addr & term_mask[g]) == (term_base[g] & term_mask[g]));
    end

    // priority walk: SRAM/I-O terms, boot sectors, main sectors
    always_comb begin
        found = 1'b0;
        win   = 0;
        for (int p = 0; p < NT; p++) begin
            int t;
            t = order_of(p, NMAIN, NBOOT, NTOP);
            if (!found && hit[t]) begin
                found = 1'b1;
                win   = t;
            end
        end

        wmask = '1;
        for (int t = 0; t < NT; t++) begin
            if (t == win) wmask = term_mask[t];
        end
        wsid = sid_of(win, NMAIN, NBOOT, NSRAM);

        sel = '0;
        for (int s = 0; s < NSEL; s++) begin
            sel[s] = dec_en && found && (s == wsid);
        end
        offset   = (dec_en && found) ? (addr & ~wmask) : '0;
        unmapped = dec_en && !found;
    end

endmodule

// File: rtl/cs_prio_decoder.sv
`timescale 1ns/1ps
module cs_prio_decoder #(
    parameter int ADDR_W    = 16,
    parameter int NMAIN     = 4,
    parameter int NBOOT     = 4,
    parameter int NSRAM     = 3,
    parameter int MAIN_BITS = 14,
    parameter int BOOT_BITS = 13,
    parameter int SRAM_BITS = 11,
    parameter int IO_BITS   = 8,
    parameter bit REG_OUT   = 1'b0,
    localparam int NT       = NMAIN + NBOOT + NSRAM + 1,
    localparam int NSEL     = NMAIN + NBOOT + 2,
    localparam int TIW      = $clog2(NT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [TIW-1:0]    cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic              cfg_start,
    input  logic [ADDR_W-1:0] addr,
    output logic              cfg_done,
    output logic              cfg_error,
    output logic [NSEL-1:0]   mem_sel,
    output logic [ADDR_W-1:0] offset,
    output logic              unmapped
);

    logic [NT-1:0]             term_en;
    logic [NT-1:0][ADDR_W-1:0] term_base;
    logic [NT-1:0][ADDR_W-1:0] term_mask;
    logic                      dec_en;
    logic [NSEL-1:0]           dec_sel;
    logic [ADDR_W-1:0]         dec_off;
    logic                      dec_unm;

    cs_term_store #(.ADDR_W(ADDR_W), .NT(NT), .TIW(TIW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .term_en(term_en), .term_base(term_base), .term_mask(term_mask)
    );

    cs_cfg_scan #(
        .ADDR_W(ADDR_W), .NMAIN(NMAIN), .NBOOT(NBOOT), .NSRAM(NSRAM), .NT(NT),
        .MAIN_BITS(MAIN_BITS), .BOOT_BITS(BOOT_BITS),
        .SRAM_BITS(SRAM_BITS), .IO_BITS(IO_BITS)
    ) u_scan (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_start(cfg_start),
        .term_en(term_en), .term_base(term_base), .term_mask(term_mask),
        .cfg_done(cfg_done), .cfg_error(cfg_error)
    );

    assign dec_en = cfg_done & ~cfg_error;

    cs_sel_resolve #(
        .ADDR_W(ADDR_W), .NMAIN(NMAIN), .NBOOT(NBOOT), .NSRAM(NSRAM),
        .NT(NT), .NSEL(NSEL)
    ) u_resolve (
        .dec_en(dec_en), .addr(addr),
        .term_en(term_en), .term_base(term_base), .term_mask(term_mask),
        .sel(dec_sel), .offset(dec_off), .unmapped(dec_unm)
    );

    if (REG_OUT) begin : g_reg_out
        typedef struct packed {
            logic [NSEL-1:0]   sel;
            logic [ADDR_W-1:0] off;
            logic              unm;
        } out_t;
        out_t o_d, o_q;
        always_comb begin
            o_d.sel = dec_sel;
            o_d.off = dec_off;
            o_d.unm = dec_unm;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) o_q <= '0;
            else        o_q <= o_d;
        end
        assign mem_sel  = o_q.sel;
        assign offset   = o_q.off;
        assign unmapped = o_q.unm;
    end else begin : g_comb_out
        assign mem_sel  = dec_sel;
        assign offset   = dec_off;
        assign unmapped = dec_unm;
    end

    // ---------------- assertions ----------------
    p_sel_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_sel));

    p_unmapped_no_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_unm |-> (dec_sel == '0));

    p_idle_before_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> ((dec_sel == '0) && !dec_unm));

    p_error_blocks_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> ((dec_sel == '0) && !dec_unm));

    p_offset_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_sel == '0) |-> (dec_off == '0));

endmodule

// File: tb/cs_prio_decoder_bench.sv
`timescale 1ns/1ps
module cs_prio_decoder_bench;

    localparam int AW   = 16;
    localparam int NT   = 12;
    localparam int NSEL = 10;
    localparam int IW   = 4;
    localparam int SEL_SRAM = 8;
    localparam int SEL_IO   = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_idx = '0;
    logic            cfg_en = 1'b0;
    logic [AW-1:0]   cfg_base = '0;
    logic [AW-1:0]   cfg_mask = '0;
    logic            cfg_start = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic            cfg_done, cfg_error, unmapped;
    logic [NSEL-1:0] mem_sel;
    logic [AW-1:0]   offset;

    int n_total = 0;
    int n_fail  = 0;

    typedef struct {
        logic [AW-1:0]   a;
        logic [NSEL-1:0] sel;
        logic [AW-1:0]   off;
        logic            unm;
        string           req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    cs_prio_decoder u_cs_prio_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_start(cfg_start),
        .addr(addr),
        .cfg_done(cfg_done), .cfg_error(cfg_error),
        .mem_sel(mem_sel), .offset(offset), .unmapped(unmapped)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NSEL-1:0] bit_of(int s);
        logic [NSEL-1:0] v;
        v = '0;
        if (s >= 0) v[s] = 1'b1;
        return v;
    endfunction

    // monitor: pops one expected item per cycle and compares at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(mem_sel == e.sel, e.req, $sformatf("mem_sel @%h", e.a), 32'(mem_sel), 32'(e.sel));
            chk(offset == e.off, e.req, $sformatf("offset @%h", e.a), 32'(offset), 32'(e.off));
            chk(unmapped == e.unm, e.req, $sformatf("unmapped @%h", e.a), 32'(unmapped), 32'(e.unm));
        end
    end

    // driver: applies an address and pushes its expected result
    task automatic dec(input logic [AW-1:0] a, input int s, input logic [AW-1:0] off,
                       input logic unm, input string req);
        exp_t e;
        @(posedge clk); #1;
        addr  = a;
        e.a   = a;
        e.sel = bit_of(s);
        e.off = off;
        e.unm = unm;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic wr(input int idx, input logic en, input logic [AW-1:0] b,
                      input logic [AW-1:0] m);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_en = en; cfg_base = b; cfg_mask = m;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic scan(input logic exp_err, input string req);
        int cyc;
        @(posedge clk); #1;
        cfg_start = 1'b1;
        @(posedge clk); #1;
        cfg_start = 1'b0;
        cyc = 1;
        @(negedge clk);
        while (!cfg_done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc <= NT * NT + 4, "R3", "scan cycles", 32'(cyc), 32'(NT * NT + 4));
        chk(cfg_done == 1'b1, "R3", "cfg_done", 32'(cfg_done), 32'd1);
        chk(cfg_error == exp_err, req, "cfg_error", 32'(cfg_error), 32'(exp_err));
    endtask

    initial begin
        #400000;
        n_fail++;
        n_total++;
        $display("FAIL R3 watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cfg_done == 1'b0, "R1", "cfg_done", 32'(cfg_done), 32'd0);
        chk(cfg_error == 1'b0, "R1", "cfg_error", 32'(cfg_error), 32'd0);
        chk(mem_sel == '0, "R1", "mem_sel", 32'(mem_sel), 32'd0);
        chk(unmapped == 1'b0, "R1", "unmapped", 32'(unmapped), 32'd0);
        rst_n = 1'b1;

        // worked case: main0 8000-BFFF, boot0 8000-9FFF, SRAM 8000-87FF
        wr(0, 1'b1, 16'h8000, 16'hC000);
        wr(4, 1'b1, 16'h8000, 16'hE000);
        wr(8, 1'b1, 16'h8000, 16'hF800);
        @(negedge clk);
        chk(cfg_done == 1'b0, "R2", "done after write", 32'(cfg_done), 32'd0);
        dec(16'h8000, -1, 16'h0000, 1'b0, "R2");
        drain();

        scan(1'b0, "R3");
        dec(16'h8000, SEL_SRAM, 16'h0000, 1'b0, "R5");
        dec(16'h87FF, SEL_SRAM, 16'h07FF, 1'b0, "R5");
        dec(16'h8800, 4,        16'h0800, 1'b0, "R5");
        dec(16'h9FFF, 4,        16'h1FFF, 1'b0, "R11");
        dec(16'hA000, 0,        16'h2000, 1'b0, "R5");
        dec(16'hBFFF, 0,        16'h3FFF, 1'b0, "R4");
        dec(16'h0000, -1,       16'h0000, 1'b1, "R10");
        dec(16'hC000, -1,       16'h0000, 1'b1, "R10");
        drain();

        // R6: extra SRAM windows, plus an I/O window
        wr(9,  1'b1, 16'h0000, 16'hF800);
        wr(10, 1'b1, 16'hF000, 16'hFF00);
        wr(11, 1'b1, 16'hFF00, 16'hFF00);
        scan(1'b0, "R7");
        dec(16'h0400, SEL_SRAM, 16'h0400, 1'b0, "R6");
        dec(16'hF080, SEL_SRAM, 16'h0080, 1'b0, "R6");
        dec(16'hFF10, SEL_IO,   16'h0010, 1'b0, "R12");
        dec(16'hF100, -1,       16'h0000, 1'b1, "R10");
        dec(16'h0800, -1,       16'h0000, 1'b1, "R4");
        drain();

        // R7: second main sector inside main0's range
        wr(1, 1'b1, 16'hA000, 16'hE000);
        @(negedge clk);
        chk(cfg_done == 1'b0, "R2", "done after write", 32'(cfg_done), 32'd0);
        scan(1'b1, "R7");
        dec(16'h8000, -1, 16'h0000, 1'b0, "R9");
        dec(16'h0000, -1, 16'h0000, 1'b0, "R9");
        drain();

        // disabled term does not count; boot-vs-boot overlap does
        wr(1, 1'b0, 16'hA000, 16'hE000);
        wr(5, 1'b1, 16'h8000, 16'hF000);
        scan(1'b1, "R7");
        wr(5, 1'b0, 16'h8000, 16'hF000);
        scan(1'b0, "R4");

        // SRAM vs I/O overlap
        wr(11, 1'b1, 16'hF000, 16'hFF00);
        scan(1'b1, "R7");
        wr(11, 1'b1, 16'hFF00, 16'hFF00);

        // R8: main window of 32K exceeds 16K sector
        wr(0, 1'b1, 16'h0000, 16'h8000);
        scan(1'b1, "R8");
        wr(0, 1'b1, 16'h8000, 16'hC000);

        // R8: boot window of exactly 8K is legal, SRAM terms may overlap each other
        wr(9, 1'b1, 16'h8000, 16'hFC00);
        scan(1'b0, "R7");
        dec(16'h8100, SEL_SRAM, 16'h0100, 1'b0, "R11");
        dec(16'h9000, 4,        16'h1000, 1'b0, "R8");
        dec(16'hB000, 0,        16'h3000, 1'b0, "R12");
        drain();

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule